// File: doc/BRIEF.md
# Host Channel SCI Interrupt Shaper

This block is the configuration register and the system-control-interrupt (SCI) pin driver for one power-management mailbox channel between a host and an embedded core. The core reaches an 8-bit configuration register over a simple write/read bus. The register holds two core interrupt enables, a 3-bit shaping code, an output inversion bit and an enhanced-control bit. The mailbox itself is outside the block. It appears only as three inputs: the input-buffer-full flag, the output-buffer-full flag and a one-cycle strobe marking a write into the output buffer.

With enhanced control on, the SCI pin is produced by a hardware shaper. The shaping code picks either a level that follows the output-buffer-full flag, or a fixed-width high pulse of 1, 2, 4, 8 or 16 clocks that fires on each output-buffer write. With enhanced control off, the pin passes through a legacy SCI input from elsewhere. Inversion applies in both cases. A build parameter selects a channel variant in which enhanced control is hard-wired on.

Top module: `hostSciShaper`

## Requirements
- R1: After reset the register reads 0x40 (0xC0 in the hard-wired variant), coreIrq is 0, and sciPin is 1 while legacySci is 0.
- R2: Register bit 2 always reads 0, and writes to it are ignored. Bits 0, 1 and 3 to 6 read back the last value written to them, with a write taking effect on the clock edge that samples wrEn.
- R3: Bit 7 (enhanced control) is writable when FIXED_ENH=0. When FIXED_ENH=1 it always reads 1 and writes to it are ignored.
- R4: Level mode (bits 5:3 = 000, enhanced on): one cycle after obfFlag is sampled, the shaper output equals obfFlag.
- R5: Pulse mode codes 001, 010, 011, 100 and 101 give widths of 1, 2, 4, 8 and 16 cycles. After an edge samples obWrite=1, the shaper output is high for exactly that many cycles, starting right after that edge.
- R6: An obWrite sampled while a pulse is still active restarts the pulse, so the pulse runs the full width from the new write.
- R7: Codes 110 and 111 never assert the shaper output, whatever obfFlag and obWrite do.
- R8: sciPin equals the selected source XOR bit 6. A 0 in bit 6 gives an active-high pin and a 1 gives an active-low pin.
- R9: With bit 7 = 0, the source is legacySci delayed by one register, and inversion still applies.
- R10: coreIrq, one cycle after sampling, equals (bit0 AND ibfFlag) OR (bit1 AND obfFlag).
- R11: obWrite has no effect in level mode, and obfFlag has no effect in pulse mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 8 | Register write data |
| rdData | output | 8 | Current register value |
| ibfFlag | input | 1 | Input buffer full flag |
| obfFlag | input | 1 | Output buffer full flag |
| obWrite | input | 1 | One-cycle strobe for an output buffer write |
| legacySci | input | 1 | SCI source used when enhanced control is off |
| coreIrq | output | 1 | Interrupt request to the core |
| sciPin | output | 1 | SCI pin to the host |

## Verification
Every result has a fixed latency. A register write shows on rdData right after the sampling edge. coreIrq, level-mode output and legacy pass-through follow their inputs by exactly one edge. A pulse occupies the N cycles after the edge that samples obWrite. Mode and inversion changes act on sciPin immediately after the write edge. The bench changes inputs on falling edges and checks on the next falling edge. It steps a cycle-accurate arithmetic model of the shaper once per edge, so every pulse cycle and every trailing low cycle is compared at its due cycle.

// File: rtl/hsciPkg.sv
package hsciPkg;
  localparam int PULSE_LOG2_MAX = 4;
  localparam int CNT_W = PULSE_LOG2_MAX + 1;
  localparam int REG_W = 8;
  localparam logic [REG_W-1:0] RESET_VAL = 8'h40;
  localparam logic [REG_W-1:0] WRITE_MASK = 8'hFB;
  localparam int BIT_IBF_EN = 0;
  localparam int BIT_OB_EN = 1;
  localparam int MODE_LO = 3;
  localparam int MODE_HI = 5;
  localparam int BIT_INV = 6;
  localparam int BIT_ENH = 7;
  localparam logic [2:0] MODE_LEVEL = 3'd0;
  localparam logic [2:0] MODE_PULSE_LAST = 3'd5;

  typedef struct packed {
    logic levelMode;
    logic pulseMode;
    logic loadPulse;
    logic [CNT_W-1:0] width;
    logic invert;
    logic useShaper;
    logic irqRaw;
  } shapeStrobes_t;
endpackage

// File: rtl/hsciCtrl.sv
module hsciCtrl
  import hsciPkg::*;
#(
  parameter bit FIXED_ENH = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic wrEn,
  input  logic [REG_W-1:0] wrData,
  input  logic ibfFlag,
  input  logic obfFlag,
  input  logic obWrite,
  output logic [REG_W-1:0] rdData,
  output shapeStrobes_t strobes
);
  logic [BIT_ENH-1:0] lowQ;
  logic enhQ;
  logic [2:0] modeCode;
  logic [REG_W-1:0] maskedWr;

  assign maskedWr = wrData & WRITE_MASK;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lowQ <= RESET_VAL[BIT_ENH-1:0];
    else if (wrEn) lowQ <= maskedWr[BIT_ENH-1:0];
  end

  generate
    if (FIXED_ENH) begin : gEnhFixed
      assign enhQ = 1'b1;
    end else begin : gEnhReg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) enhQ <= RESET_VAL[BIT_ENH];
        else if (wrEn) enhQ <= maskedWr[BIT_ENH];
      end
    end
  endgenerate

  assign rdData = {enhQ, lowQ};
  assign modeCode = lowQ[MODE_HI:MODE_LO];

  always_comb begin
    strobes.levelMode = (modeCode == MODE_LEVEL);
    strobes.pulseMode = (modeCode != MODE_LEVEL) && (modeCode <= MODE_PULSE_LAST);
    strobes.loadPulse = strobes.pulseMode && obWrite;
    strobes.width = CNT_W'(1) << (modeCode - 3'd1);
    strobes.invert = lowQ[BIT_INV];
    strobes.useShaper = enhQ;
    strobes.irqRaw = (lowQ[BIT_IBF_EN] && ibfFlag) || (lowQ[BIT_OB_EN] && obfFlag);
  end
endmodule

// File: rtl/hsciDatapath.sv
module hsciDatapath
  import hsciPkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  shapeStrobes_t strobes,
  input  logic obfFlag,
  input  logic legacySci,
  output logic coreIrq,
  output logic sciPin
);
  logic [CNT_W-1:0] pulseCnt;
  logic levelQ;
  logic legacyQ;
  logic irqQ;
  logic shaperOut;
  logic srcSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pulseCnt <= '0;
    else if (!strobes.pulseMode) pulseCnt <= '0;
    else if (strobes.loadPulse) pulseCnt <= strobes.width;
    else if (pulseCnt != '0) pulseCnt <= pulseCnt - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      levelQ <= 1'b0;
      legacyQ <= 1'b0;
      irqQ <= 1'b0;
    end else begin
      levelQ <= obfFlag;
      legacyQ <= legacySci;
      irqQ <= strobes.irqRaw;
    end
  end

  always_comb begin
    if (strobes.levelMode) shaperOut = levelQ;
    else if (strobes.pulseMode) shaperOut = (pulseCnt != '0);
    else shaperOut = 1'b0;
    srcSel = strobes.useShaper ? shaperOut : legacyQ;
  end

  assign sciPin = srcSel ^ strobes.invert;
  assign coreIrq = irqQ;
endmodule

// File: rtl/hostSciShaper.sv
module hostSciShaper
  import hsciPkg::*;
#(
  parameter bit FIXED_ENH = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic wrEn,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  input  logic ibfFlag,
  input  logic obfFlag,
  input  logic obWrite,
  input  logic legacySci,
  output logic coreIrq,
  output logic sciPin
);
  shapeStrobes_t strobes;

  hsciCtrl #(.FIXED_ENH(FIXED_ENH)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .ibfFlag(ibfFlag), .obfFlag(obfFlag), .obWrite(obWrite),
    .rdData(rdData), .strobes(strobes)
  );

  hsciDatapath uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .obfFlag(obfFlag),
    .legacySci(legacySci), .coreIrq(coreIrq), .sciPin(sciPin)
  );
endmodule

// File: rtl/hsciChecker.sv
module hsciChecker (
  input logic clk,
  input logic rstN,
  input logic [7:0] rdData,
  input logic ibfFlag,
  input logic obfFlag,
  input logic obWrite,
  input logic legacySci,
  input logic coreIrq,
  input logic sciPin
);
  // R10: interrupt follows the enabled flags one edge later
  a_r10_irq_follows: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> coreIrq == (($past(rdData[0]) && $past(ibfFlag)) ||
                                ($past(rdData[1]) && $past(obfFlag))));

  // R7: reserved shaping codes never assert the pin
  a_r7_reserved_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[7] && rdData[5:4] == 2'b11) |-> sciPin == rdData[6]);

  // R4: level mode tracks the output buffer flag
  a_r4_level_track: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && rdData[7] && rdData[5:3] == 3'd0) |->
      sciPin == (rdData[6] ^ $past(obfFlag)));

  // R9: legacy pass-through with inversion
  a_r9_legacy_pass: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !rdData[7]) |-> sciPin == (rdData[6] ^ $past(legacySci)));

  // R5: a sampled buffer write asserts the pulse right after the edge
  a_r5_pulse_start: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && rdData[7] && $past(rdData[7]) && rdData[5:3] != 3'd0 &&
     rdData[5:3] <= 3'd5 && $past(rdData[5:3]) == rdData[5:3] && $past(obWrite))
      |-> sciPin != rdData[6]);
endmodule

bind hostSciShaper hsciChecker uChk (
  .clk(clk), .rstN(rstN), .rdData(rdData), .ibfFlag(ibfFlag),
  .obfFlag(obfFlag), .obWrite(obWrite), .legacySci(legacySci),
  .coreIrq(coreIrq), .sciPin(sciPin)
);

// File: tb/tb_hostSciShaper.sv
module tb_hostSciShaper;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic ibfFlag = 1'b0;
  logic obfFlag = 1'b0;
  logic obWrite = 1'b0;
  logic legacySci = 1'b0;
  logic [7:0] rdData, rdDataFx;
  logic coreIrq, coreIrqFx, sciPin, sciPinFx;
  int checkCnt = 0;
  int failCnt = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  hostSciShaper #(.FIXED_ENH(1'b0)) dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .ibfFlag(ibfFlag), .obfFlag(obfFlag), .obWrite(obWrite),
    .legacySci(legacySci), .coreIrq(coreIrq), .sciPin(sciPin)
  );

  hostSciShaper #(.FIXED_ENH(1'b1)) dutFx (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdDataFx),
    .ibfFlag(ibfFlag), .obfFlag(obfFlag), .obWrite(obWrite),
    .legacySci(legacySci), .coreIrq(coreIrqFx), .sciPin(sciPinFx)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic writeReg(input logic [7:0] d);
    wrEn = 1'b1;
    wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  function automatic int pulseWidth(input logic [2:0] code);
    if (code >= 3'd1 && code <= 3'd5) return 1 << (code - 1);
    return 0;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checkCnt++;
      failCnt++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reset read", rdData, 8'h40);
    check("R1 reset read fixed", rdDataFx, 8'hC0);
    check("R1 reset irq", {7'd0, coreIrq}, 8'd0);
    check("R1 reset pin", {7'd0, sciPin}, 8'd1);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 pin after release", {7'd0, sciPin}, 8'd1);

    // R2, R3: every write value, readback on both variants
    for (int d = 0; d < 256; d++) begin
      writeReg(8'(d));
      check("R2 R3 readback", rdData, 8'(d) & 8'hFB);
      check("R3 fixed enhanced", rdDataFx, (8'(d) & 8'hFB) | 8'h80);
    end

    // R10: interrupt enables against flag combinations
    for (int e = 0; e < 4; e++) begin
      for (int f = 0; f < 4; f++) begin
        writeReg({2'b11, 3'b110, 1'b0, 2'(e)});
        ibfFlag = f[0];
        obfFlag = f[1];
        @(negedge clk);
        check("R10 irq", {7'd0, coreIrq},
              {7'd0, (e[0] & f[0]) | (e[1] & f[1])});
        ibfFlag = 1'b0;
        obfFlag = 1'b0;
        @(negedge clk);
      end
    end

    // R4 R5 R6 R7 R8 R11: sweep every code and both inversions
    for (int inv = 0; inv < 2; inv++) begin
      for (int code = 0; code < 8; code++) begin
        int cnt;
        int w;
        logic shp;
        writeReg({1'b1, 1'(inv), 3'(code), 3'b000});
        w = pulseWidth(3'(code));
        cnt = 0;
        for (int t = 0; t < 40; t++) begin
          obWrite = (t == 0) || (t == 3);
          obfFlag = (t >= 25 && t < 28);
          @(negedge clk);
          if (w > 0) begin
            if (obWrite) cnt = w;
            else if (cnt > 0) cnt--;
            shp = (cnt > 0);
          end else if (code == 0) begin
            shp = obfFlag;
          end else begin
            shp = 1'b0;
          end
          if (code == 0) check("R4 R11 level", {7'd0, sciPin}, {7'd0, shp ^ 1'(inv)});
          else if (w > 0) check("R5 R6 R8 R11 pulse", {7'd0, sciPin}, {7'd0, shp ^ 1'(inv)});
          else check("R7 reserved", {7'd0, sciPin}, {7'd0, 1'(inv)});
          check("R8 fixed variant", {7'd0, sciPinFx}, {7'd0, shp ^ 1'(inv)});
        end
        obWrite = 1'b0;
        obfFlag = 1'b0;
        @(negedge clk);
      end
    end

    // R9: legacy pass-through with both inversions
    for (int inv = 0; inv < 2; inv++) begin
      writeReg({1'b0, 1'(inv), 3'b001, 3'b000});
      for (int t = 0; t < 12; t++) begin
        legacySci = ((t * 5) % 3) == 1;
        obWrite = (t == 2);
        @(negedge clk);
        check("R9 legacy", {7'd0, sciPin}, {7'd0, legacySci ^ 1'(inv)});
      end
      legacySci = 1'b0;
      obWrite = 1'b0;
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end
endmodule